// File: doc/BRIEF.md
# Serial Control Port with Interrupts

This block is the host-facing slave end of a four-wire serial control link. The host drives a serial clock, a command data line and an active-low chip select. The block answers on a reply data line that it enables only while it sends. Bytes travel MSB first. The first byte of every chip-select frame is a command byte: bits [7:1] hold an opcode and bit 0 holds a device address. That address is compared with a strap input, so two identical devices can share one bus. A write opcode takes one data byte and loads an internal register. A read opcode makes the block shift back one reply byte.

The block also gathers six event pulses from neighbouring datapath logic into a sticky status register. It drives an active-low open-drain interrupt request whenever an enabled status bit is set, and reading the status register clears it. A power-save output is raised only when the wake pin and bit 0 of the control register are both 1. All host pins are resynchronised into the block's own clock, which must run several times faster than the serial clock.

Top module: `scp_top`

## Requirements
- R1: Command data is shifted in MSB first on rising serial-clock edges. A complete frame `{opcode,addr}` + data byte with opcode 1 loads the control register (`ctrl_o`). Opcode 2 loads the interrupt mask (bits [5:0]). Opcode 3 loads the transmit byte (`tx_data_o`).
- R2: Raising `cs_n_i` before a byte is complete discards that partial byte, and no register changes.
- R3: `reply_en_o` is 0 while chip select is high and during the command byte. It becomes 1 on the serial-clock falling edge that follows a valid read command byte. The reply line changes only on falling edges, and is high impedance whenever `reply_en_o` is 0.
- R4: A frame whose command-byte bit 0 differs from `addr_sel_i` is ignored entirely: no register write and no reply.
- R5: Read opcodes return one byte MSB first. Opcode 8 returns status, zero-extended. Opcode 9 returns `rx_data_i`. Opcode 10 returns the control register. Opcode 11 returns the mask.
- R6: A one-cycle pulse on `evt_i[k]` sets status bit k on the next clock. Bit 0 is tone measured, 1 is receive byte ready, 2 is transmit buffer ready, 3 is no-tone timeout, 4 is receive overrun and 5 is send complete. The bit stays set until it is read.
- R7: `irq_pull_o` is 1 (pin pulled low) exactly when some status bit and the matching mask bit are both 1. When it is 0 the pin is high impedance.
- R8: Reading status clears the bits that were returned. An event arriving in the same cycle stays set.
- R9: `pwr_save_o` is 1 only when `wake_i` and control bit 0 are both 1. Clearing either one releases it.
- R10: A command byte with an opcode other than 1, 2, 3, 8, 9, 10 or 11 is ignored: no write and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host serial clock |
| cs_n_i | input | 1 | Active-low chip select |
| cmd_i | input | 1 | Serial command data from the host |
| addr_sel_i | input | 1 | Device address strap |
| reply_d_o | output | 1 | Serial reply data value |
| reply_en_o | output | 1 | Reply line driver enable; 0 means high impedance |
| irq_pull_o | output | 1 | 1 pulls the interrupt line low; 0 leaves it floating |
| wake_i | input | 1 | External wake pin |
| evt_i | input | 6 | Event pulses from datapath logic |
| rx_data_i | input | 8 | Received byte offered for reading |
| ctrl_o | output | 8 | Control register |
| tx_data_o | output | 8 | Transmit byte register |
| pwr_save_o | output | 1 | Power-save-all qualification |

## Verification
On every cycle, the assertions check four things. The reply driver drops whenever chip select is high. Register writes come only from a byte completed while chip select was low. Event pulses always land in status and survive a concurrent clear. A status read really empties the bits it reported. Only the bench scenarios can show the frame-level outcomes: addressing by the strap, aborts partway through a byte, unknown opcodes leaving registers intact, MSB-first reply ordering, and mask-gated interrupt behaviour seen at the pins.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = BYTE_W - 1;

  typedef enum logic [1:0] {FR_CMD, FR_DATA, FR_READ, FR_SKIP} frame_st_e;

  localparam logic [OP_W-1:0] OP_WR_CTRL = 7'd1;
  localparam logic [OP_W-1:0] OP_WR_MASK = 7'd2;
  localparam logic [OP_W-1:0] OP_WR_TX   = 7'd3;
  localparam logic [OP_W-1:0] OP_RD_STAT = 7'd8;
  localparam logic [OP_W-1:0] OP_RD_RX   = 7'd9;
  localparam logic [OP_W-1:0] OP_RD_CTRL = 7'd10;
  localparam logic [OP_W-1:0] OP_RD_MASK = 7'd11;

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return (op == OP_WR_CTRL) || (op == OP_WR_MASK) || (op == OP_WR_TX);
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return (op == OP_RD_STAT) || (op == OP_RD_RX) ||
           (op == OP_RD_CTRL) || (op == OP_RD_MASK);
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
module scp_frame import scp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              din_s,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rd_val,
  output logic              wr_stb,
  output logic [OP_W-1:0]   op,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_take,
  output logic              reply_d,
  output logic              reply_en
);
  logic              sclk_q;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] sh, reply_sh;
  logic              load_pend;
  frame_st_e         st;

  wire              rise      = sclk_s & ~sclk_q;
  wire              fall      = ~sclk_s & sclk_q;
  wire [BYTE_W-1:0] nb        = {sh[BYTE_W-2:0], din_s};
  wire              byte_done = rise & ~cs_n_s & (bit_cnt == 3'd7);

  // reply byte is captured on the falling edge after a read command
  assign rd_take = fall & ~cs_n_s & load_pend;
  assign reply_d = reply_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; bit_cnt <= '0; sh <= '0; reply_sh <= '0;
      load_pend <= 1'b0; reply_en <= 1'b0; st <= FR_CMD;
      wr_stb <= 1'b0; op <= '0; wr_data <= '0;
    end else begin
      sclk_q <= sclk_s;
      wr_stb <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0; st <= FR_CMD; load_pend <= 1'b0;
        reply_en <= 1'b0; reply_sh <= '0;
      end else begin
        if (rise) begin
          sh      <= nb;
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            FR_CMD: begin
              if (nb[0] != addr_sel) st <= FR_SKIP;
              else if (op_is_write(nb[BYTE_W-1:1])) begin
                st <= FR_DATA; op <= nb[BYTE_W-1:1];
              end else if (op_is_read(nb[BYTE_W-1:1])) begin
                st <= FR_READ; op <= nb[BYTE_W-1:1]; load_pend <= 1'b1;
              end else st <= FR_SKIP;
            end
            FR_DATA: begin
              wr_stb <= 1'b1; wr_data <= nb; st <= FR_SKIP;
            end
            default: ;
          endcase
        end
        if (rd_take) begin
          reply_sh <= rd_val; reply_en <= 1'b1; load_pend <= 1'b0;
        end else if (fall && reply_en) begin
          reply_sh <= {reply_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_REPLY_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !reply_en); // R3
  AST_WRITE_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(byte_done)); // R2
  AST_SKIP_NO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_SKIP) |-> !load_pend); // R4 R10
endmodule

// File: rtl/scp_status.sv
module scp_status #(
  parameter int NEVT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt,
  input  logic            clr,
  input  logic [NEVT-1:0] mask,
  output logic [NEVT-1:0] status,
  output logic            irq_pull
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (clr ? '0 : status) | evt;
  end

  assign irq_pull = |(status & mask);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R6
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (status == '0)); // R8
endmodule

// File: rtl/scp_top.sv
module scp_top import scp_pkg::*; #(
  parameter int NEVT = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              cmd_i,
  input  logic              addr_sel_i,
  output logic              reply_d_o,
  output logic              reply_en_o,
  output logic              irq_pull_o,
  input  logic              wake_i,
  input  logic [NEVT-1:0]   evt_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              pwr_save_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0]  pins_s;
  logic              wr_stb, rd_take;
  logic [OP_W-1:0]   op;
  logic [BYTE_W-1:0] wr_data, rd_val, ctrl_q, tx_q;
  logic [NEVT-1:0]   mask_q, status;

  scp_sync #(.N(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_i, cs_n_i, cmd_i}), .q(pins_s));

  scp_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]),
    .din_s(pins_s[0]), .addr_sel(addr_sel_i), .rd_val(rd_val),
    .wr_stb(wr_stb), .op(op), .wr_data(wr_data), .rd_take(rd_take),
    .reply_d(reply_d_o), .reply_en(reply_en_o));

  scp_status #(.NEVT(NEVT)) u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_i),
    .clr(rd_take && (op == OP_RD_STAT)), .mask(mask_q),
    .status(status), .irq_pull(irq_pull_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; mask_q <= '0; tx_q <= '0;
    end else if (wr_stb) begin
      if (op == OP_WR_CTRL) ctrl_q <= wr_data;
      if (op == OP_WR_MASK) mask_q <= wr_data[NEVT-1:0];
      if (op == OP_WR_TX)   tx_q   <= wr_data;
    end
  end

  always_comb begin
    rd_val = '0;
    case (op)
      OP_RD_STAT: rd_val[NEVT-1:0] = status;
      OP_RD_RX:   rd_val = rx_data_i;
      OP_RD_CTRL: rd_val = ctrl_q;
      OP_RD_MASK: rd_val[NEVT-1:0] = mask_q;
      default:    rd_val = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign tx_data_o  = tx_q;
  assign pwr_save_o = wake_i & ctrl_q[0];

  AST_PSAVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_save_o) |-> (!wake_i || !ctrl_q[0])); // R9
endmodule

// File: tb/scp_top_tb.sv
module scp_top_tb;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, cmd = 1'b0, addr_sel = 1'b0, wake = 1'b0;
  logic [5:0] evt = '0;
  logic [7:0] rx_data = '0;
  logic reply_d, reply_en, irq_pull, pwr_save;
  logic [7:0] ctrl, tx_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scp_top u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .cmd_i(cmd),
    .addr_sel_i(addr_sel), .reply_d_o(reply_d), .reply_en_o(reply_en),
    .irq_pull_o(irq_pull), .wake_i(wake), .evt_i(evt), .rx_data_i(rx_data),
    .ctrl_o(ctrl), .tx_data_o(tx_data), .pwr_save_o(pwr_save));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame: command byte b0, then b1, nbits total bits
  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int nbits,
                       output logic [7:0] rep, output logic en_cmd, output logic en_rep);
    rep = '0; en_cmd = 1'b0; en_rep = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sclk = 1'b0;
      cmd  = (i < 8) ? b0[7-i] : b1[15-i];
      wait_clk(H);
      if (i < 8) en_cmd = en_cmd | reply_en;
      else begin
        rep[15-i] = reply_d;
        en_rep = en_rep & reply_en;
      end
      sclk = 1'b1;
      wait_clk(H);
    end
    sclk = 1'b0;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(4*H);
  endtask

  task automatic wr(input logic [7:0] b0, input logic [7:0] d);
    logic [7:0] r; logic a, b;
    frame(b0, d, 16, r, a, b);
  endtask

  task automatic rd(input logic [7:0] b0, output logic [7:0] r, output logic en);
    logic a;
    frame(b0, 8'h00, 16, r, a, en);
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk) evt = v;
    @(negedge clk) evt = '0;
    wait_clk(2);
  endtask

  task automatic t_reset;
    check("R7 irq after reset", irq_pull, 0);
    check("R3 reply_en after reset", reply_en, 0);
    check("R1 ctrl after reset", ctrl, 0);
    check("R9 psave after reset", pwr_save, 0);
  endtask

  task automatic t_write;
    logic [7:0] r; logic en;
    wr(8'h02, 8'hA4);
    check("R1 ctrl write", ctrl, 8'hA4);
    rd(8'h14, r, en);
    check("R5 ctrl readback", r, 8'hA4);
    check("R3 reply enabled", en, 1);
    wr(8'h06, 8'h5A);
    check("R1 tx write", tx_data, 8'h5A);
  endtask

  task automatic t_addr;
    logic [7:0] r; logic en;
    addr_sel = 1'b1;
    wr(8'h02, 8'h33);
    check("R4 foreign write ignored", ctrl, 8'hA4);
    rd(8'h14, r, en);
    check("R4 foreign read silent", en, 0);
    rd(8'h15, r, en);
    check("R4 own address read", r, 8'hA4);
    addr_sel = 1'b0;
  endtask

  task automatic t_abort;
    logic [7:0] r; logic a, b;
    frame(8'h02, 8'h11, 13, r, a, b);
    check("R2 partial byte discarded", ctrl, 8'hA4);
    frame(8'h02, 8'h11, 5, r, a, b);
    check("R2 partial command discarded", ctrl, 8'hA4);
  endtask

  task automatic t_unknown;
    logic [7:0] r; logic en;
    wr(8'h0A, 8'h77);
    check("R10 unknown write op", ctrl, 8'hA4);
    check("R10 tx untouched", tx_data, 8'h5A);
    rd(8'h28, r, en);
    check("R10 unknown read silent", en, 0);
  endtask

  task automatic t_status;
    logic [7:0] r; logic en;
    pulse(6'b001001);
    check("R7 masked events no irq", irq_pull, 0);
    rd(8'h10, r, en);
    check("R6 status bits 0 and 3", r, 8'h09);
    rd(8'h10, r, en);
    check("R8 status cleared", r, 8'h00);
    pulse(6'b110000);
    rd(8'h10, r, en);
    check("R6 status bits 4 and 5", r, 8'h30);
  endtask

  task automatic t_irq;
    logic [7:0] r; logic en;
    wr(8'h04, 8'h08);
    rd(8'h16, r, en);
    check("R5 mask readback", r, 8'h08);
    pulse(6'b000010);
    check("R7 disabled source no irq", irq_pull, 0);
    pulse(6'b001000);
    check("R7 enabled source irq", irq_pull, 1);
    rd(8'h10, r, en);
    check("R8 read returns both", r, 8'h0A);
    check("R8 irq released by read", irq_pull, 0);
  endtask

  task automatic t_rx;
    logic [7:0] r, r2; logic a, en;
    rx_data = 8'hC3;
    frame(8'h12, 8'h00, 16, r, a, en);
    check("R5 rx data MSB first", r, 8'hC3);
    check("R3 silent during command byte", a, 0);
    rx_data = 8'h81;
    rd(8'h12, r2, en);
    check("R5 rx data edges", r2, 8'h81);
  endtask

  task automatic t_psave;
    wr(8'h02, 8'h01);
    wake = 1'b0; wait_clk(2);
    check("R9 wake low", pwr_save, 0);
    wake = 1'b1; wait_clk(2);
    check("R9 both set", pwr_save, 1);
    wr(8'h02, 8'h00);
    check("R9 bit cleared", pwr_save, 0);
    wake = 1'b0;
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write();
    t_addr();
    t_abort();
    t_unknown();
    t_status();
    t_irq();
    t_rx();
    t_psave();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule